// File: doc/BRIEF.md
# Flash Erase and Status Engine

This block keeps the embedded-operation status of a parallel NOR flash model that uses the unlock-style command set. A command decoder in front of it gives it the accepted operations as one-cycle strobes. These are a chip erase, a sector erase with its address, and a program with its data byte. The decoder also passes each host read of the status byte and the current unlock-bypass flag. The engine returns a status byte that carries a data-polling bit (bit 7) and a toggle bit (bit 6), plus a busy flag. For each erase it issues a request that tells the storage array which byte range to fill with ones. When the busy timer runs out it raises a done event, which tells the decoder where to return.

The erase sector that an address falls in is resolved from a table of up to four erase regions. Each region has a block count and a power-of-two sector length. The regions lie one after another from address zero. A sector erase clears exactly one sector, aligned down to that sector's length. The busy time is a parameterised cycle count for each kind of erase. Chip erase defaults to ten times the sector erase time.

Top module: `nor_op_status`

## Requirements
- R1: After synchronous reset the status byte is 0x00, busy is low, and neither a clear request nor a done event is issued. Status bits 5..0 are always zero.
- R2: A program strobe accepted while idle sets status bit 7 to the complement of bit 7 of the data byte, one cycle later. Bit 6 is unchanged and busy stays low.
- R3: A status read while busy flips status bit 6 in the next cycle. A status read while idle leaves the status byte unchanged.
- R4: An erase strobe accepted while idle clears status bit 7 and raises busy in the next cycle. Bit 6 is unchanged.
- R5: A chip erase issues a one-cycle clear request in the cycle after the strobe, with base 0 and length equal to the total array size (the sum of block count times sector length over all regions).
- R6: A sector erase finds its sector length by walking the regions in order from address 0 and taking the first region whose end lies above the address. It issues a one-cycle clear request in the cycle after the strobe, with that length and the address aligned down to it.
- R7: A sector erase address at or beyond the end of the last region uses the sector length of the last region.
- R8: Busy stays high for exactly CHIP_BUSY_CYCLES cycles after a chip erase and SECTOR_BUSY_CYCLES cycles after a sector erase.
- R9: On the edge where busy falls after its count, done_o pulses for one cycle and status bit 7 is inverted.
- R10: done_bypass_o, valid with done_o, equals bypass_i as sampled on the last busy cycle. A value of 1 means return to the bypass command state; 0 means return to normal read mode.
- R11: Erase and program strobes that arrive while busy are ignored. They produce no clear request, do not change status bit 7, and do not restart the busy count.
- R12: When strobes coincide while idle, chip erase wins over sector erase, and sector erase wins over program.
- R13: A reset during busy drops busy and clears the status to 0x00. No done event follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_chip_i | input | 1 | Start chip erase strobe |
| erase_sector_i | input | 1 | Start sector erase strobe |
| program_i | input | 1 | Program write strobe |
| op_addr_i | input | ADDR_W | Byte address for sector erase |
| prog_data_i | input | 8 | Data byte of the program write |
| status_rd_i | input | 1 | Host read of the status byte |
| bypass_i | input | 1 | Unlock bypass active |
| status_o | output | 8 | Status byte: bit 7 polling, bit 6 toggle |
| busy_o | output | 1 | Erase in progress |
| clr_req_o | output | 1 | One-cycle request to fill a range with 0xFF |
| clr_base_o | output | ADDR_W | First byte of the range to clear |
| clr_len_o | output | ADDR_W+1 | Byte length of the range to clear |
| done_o | output | 1 | One-cycle erase completion event |
| done_bypass_o | output | 1 | Return target with done_o: 1 bypass state, 0 read mode |

## Verification
A wrong region walk shows at once as a bad base or length on the clear request. This appears in the cycle after the sector strobe, and addresses on both sides of each region edge and past the array end expose it. A busy counter that is loaded or decremented wrongly shows as busy falling early or late. That error is only visible when the count ends, so each busy window is measured against a free-running cycle count, including after ignored strobes. A polling or toggle bit that is stuck or updated on the wrong event shows on the status byte one cycle after the read, program, start or expiry that should have moved it.

// File: rtl/nor_op_pkg.sv
package nor_op_pkg;

    localparam int MAX_REGIONS = 4;
    localparam int POLL_POS    = 7;
    localparam int TOGGLE_POS  = 6;

    typedef int unsigned region_arr_t [MAX_REGIONS];

    typedef struct packed {
        logic poll;
        logic toggle;
    } status_bits_t;

    function automatic logic [7:0] pack_status(status_bits_t s);
        logic [7:0] b;
        b = 8'h00;
        b[POLL_POS]   = s.poll;
        b[TOGGLE_POS] = s.toggle;
        return b;
    endfunction

    // End address (exclusive) of region n-1, i.e. total span of regions 0..n-1.
    function automatic int unsigned span_upto(region_arr_t blocks, region_arr_t logs, int n);
        int unsigned acc;
        acc = 0;
        for (int k = 0; k < MAX_REGIONS; k++) begin
            if (k < n) acc += blocks[k] << logs[k];
        end
        return acc;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nor_sector_locator.sv
module nor_sector_locator
    import nor_op_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          NUM_REGIONS = 4,
    parameter int          LOG_W       = 5,
    parameter region_arr_t REG_BLOCKS  = '{4, 6, 2, 4},
    parameter region_arr_t REG_LOG2    = '{10, 11, 12, 10}
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [LOG_W-1:0]  sec_log2_o,
    output logic [ADDR_W-1:0] sec_base_o
);

    logic [31:0]            addr_w;
    logic [NUM_REGIONS-1:0] below_end;
    logic [ADDR_W-1:0]      low_mask;

    assign addr_w = 32'(addr_i);

    // One comparator per region against its exclusive end address.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam int unsigned REGION_END = span_upto(REG_BLOCKS, REG_LOG2, g + 1);
        if (g == NUM_REGIONS - 1) begin : g_last
            // Addresses past the array fall into the last region.
            assign below_end[g] = 1'b1;
        end else begin : g_mid
            assign below_end[g] = (addr_w < 32'(REGION_END));
        end
    end

    // First region in walk order whose end lies above the address.
    always_comb begin
        sec_log2_o = LOG_W'(REG_LOG2[NUM_REGIONS-1]);
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (below_end[i]) sec_log2_o = LOG_W'(REG_LOG2[i]);
        end
    end

    assign low_mask   = ADDR_W'((33'd1 << sec_log2_o) - 33'd1);
    assign sec_base_o = addr_i & ~low_mask;

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             busy_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    assign busy_o   = (cnt_q != '0);
    assign expire_o = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i && !busy_o) begin
            cnt_q <= load_i;
        end else if (busy_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/nor_status_bits.sv
module nor_status_bits
    import nor_op_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_load_i,
    input  logic       prog_bit7_i,
    input  logic       erase_start_i,
    input  logic       expire_i,
    input  logic       toggle_req_i,
    output logic [7:0] status_o
);

    status_bits_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (erase_start_i) begin
            st_d.poll = 1'b0;
        end else if (prog_load_i) begin
            st_d.poll = ~prog_bit7_i;
        end else if (expire_i) begin
            st_d.poll = ~st_q.poll;
        end
        if (toggle_req_i) begin
            st_d.toggle = ~st_q.toggle;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = pack_status(st_q);

endmodule

// File: rtl/nor_op_status.sv
module nor_op_status
    import nor_op_pkg::*;
#(
    parameter int          ADDR_W             = 16,
    parameter int          NUM_REGIONS        = 4,
    parameter region_arr_t REG_BLOCKS         = '{4, 6, 2, 4},
    parameter region_arr_t REG_LOG2           = '{10, 11, 12, 10},
    parameter int unsigned CHIP_BUSY_CYCLES   = 5000,
    parameter int unsigned SECTOR_BUSY_CYCLES = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_chip_i,
    input  logic              erase_sector_i,
    input  logic              program_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [7:0]        prog_data_i,
    input  logic              status_rd_i,
    input  logic              bypass_i,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              clr_req_o,
    output logic [ADDR_W-1:0] clr_base_o,
    output logic [ADDR_W:0]   clr_len_o,
    output logic              done_o,
    output logic              done_bypass_o
);

    localparam int unsigned CHIP_BYTES = span_upto(REG_BLOCKS, REG_LOG2, NUM_REGIONS);
    localparam int          LOG_W      = 5;
    localparam int          CNT_W      = $clog2(max_u(CHIP_BUSY_CYCLES, SECTOR_BUSY_CYCLES) + 1);

    logic              busy;
    logic              expire;
    logic              accept_chip, accept_sec, accept_prog, start;
    logic [CNT_W-1:0]  load_val;
    logic [LOG_W-1:0]  sec_log2;
    logic [ADDR_W-1:0] sec_base;

    // Priority: chip erase, then sector erase, then program; nothing while busy.
    assign accept_chip = erase_chip_i && !busy;
    assign accept_sec  = erase_sector_i && !erase_chip_i && !busy;
    assign accept_prog = program_i && !erase_chip_i && !erase_sector_i && !busy;
    assign start       = accept_chip || accept_sec;
    assign load_val    = accept_chip ? CNT_W'(CHIP_BUSY_CYCLES) : CNT_W'(SECTOR_BUSY_CYCLES);

    nor_sector_locator #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .LOG_W       (LOG_W),
        .REG_BLOCKS  (REG_BLOCKS),
        .REG_LOG2    (REG_LOG2)
    ) u_locate (
        .addr_i     (op_addr_i),
        .sec_log2_o (sec_log2),
        .sec_base_o (sec_base)
    );

    nor_busy_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .load_i   (load_val),
        .busy_o   (busy),
        .expire_o (expire)
    );

    nor_status_bits u_status (
        .clk           (clk),
        .rst           (rst),
        .prog_load_i   (accept_prog),
        .prog_bit7_i   (prog_data_i[7]),
        .erase_start_i (start),
        .expire_i      (expire),
        .toggle_req_i  (status_rd_i && busy),
        .status_o      (status_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_req_o     <= 1'b0;
            clr_base_o    <= '0;
            clr_len_o     <= '0;
            done_o        <= 1'b0;
            done_bypass_o <= 1'b0;
        end else begin
            clr_req_o <= start;
            done_o    <= expire;
            if (accept_chip) begin
                clr_base_o <= '0;
                clr_len_o  <= (ADDR_W+1)'(CHIP_BYTES);
            end else if (accept_sec) begin
                clr_base_o <= sec_base;
                clr_len_o  <= (ADDR_W+1)'(1) << sec_log2;
            end
            if (expire) begin
                done_bypass_o <= bypass_i;
            end
        end
    end

    assign busy_o = busy;

endmodule

// File: rtl/nor_op_status_chk.sv
module nor_op_status_chk #(
    parameter int          ADDR_W     = 16,
    parameter int unsigned CHIP_BYTES = 28672
) (
    input logic              clk,
    input logic              rst,
    input logic              erase_chip_i,
    input logic              erase_sector_i,
    input logic              program_i,
    input logic [7:0]        prog_data_i,
    input logic              status_rd_i,
    input logic [7:0]        status_o,
    input logic              busy_o,
    input logic              clr_req_o,
    input logic [ADDR_W-1:0] clr_base_o,
    input logic [ADDR_W:0]   clr_len_o,
    input logic              done_o
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[5:0] == 6'b0);

    // R2
    program_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (program_i && !erase_chip_i && !erase_sector_i && !busy_o)
        |=> ({status_o[7], 7'b0} == ($past(~prog_data_i) & 8'h80)) && !busy_o);

    // R3
    read_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && status_rd_i) |=> status_o[6] != $past(status_o[6]));

    // R4
    erase_start_chk: assert property (@(posedge clk) disable iff (rst)
        ((erase_chip_i || erase_sector_i) && !busy_o) |=> busy_o && !status_o[7] && clr_req_o);

    // R5
    chip_range_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_chip_i && !busy_o) |=> clr_base_o == '0 && clr_len_o == (ADDR_W+1)'(CHIP_BYTES));

    // R9
    expire_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !rst_q) |-> done_o && (status_o[7] != $past(status_o[7])));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && !$past(done_o));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (erase_chip_i || erase_sector_i || program_i)) |=> !clr_req_o);

endmodule

bind nor_op_status nor_op_status_chk #(
    .ADDR_W     (ADDR_W),
    .CHIP_BYTES (CHIP_BYTES)
) u_chk (.*);

// File: tb/nor_op_status_tb.sv
module nor_op_status_tb;

    localparam int ADDR_W = 16;
    localparam int CHIP_N = 60;
    localparam int SEC_N  = 12;
    localparam int BLK [4] = '{4, 6, 2, 4};
    localparam int LG  [4] = '{10, 11, 12, 10};
    localparam int CHIP_LEN = 28672;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              erase_chip_i = 1'b0, erase_sector_i = 1'b0, program_i = 1'b0;
    logic [ADDR_W-1:0] op_addr_i = '0;
    logic [7:0]        prog_data_i = 8'h00;
    logic              status_rd_i = 1'b0, bypass_i = 1'b0;
    logic [7:0]        status_o;
    logic              busy_o, clr_req_o, done_o, done_bypass_o;
    logic [ADDR_W-1:0] clr_base_o;
    logic [ADDR_W:0]   clr_len_o;

    nor_op_status #(
        .ADDR_W             (ADDR_W),
        .CHIP_BUSY_CYCLES   (CHIP_N),
        .SECTOR_BUSY_CYCLES (SEC_N)
    ) u_dut (
        .clk(clk), .rst(rst), .erase_chip_i(erase_chip_i), .erase_sector_i(erase_sector_i),
        .program_i(program_i), .op_addr_i(op_addr_i), .prog_data_i(prog_data_i),
        .status_rd_i(status_rd_i), .bypass_i(bypass_i), .status_o(status_o), .busy_o(busy_o),
        .clr_req_o(clr_req_o), .clr_base_o(clr_base_o), .clr_len_o(clr_len_o),
        .done_o(done_o), .done_bypass_o(done_bypass_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int base; int len; string tag; } clr_item_t;
    clr_item_t clr_q[$];
    bit        done_q[$];

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_status = 8'h00;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void sector_of(int a, output int base, output int len);
        int acc;
        acc = 0;
        len = 0;
        for (int k = 0; k < 4; k++) begin
            if (len == 0 && (k == 3 || a < acc + (BLK[k] << LG[k]))) len = 1 << LG[k];
            acc += BLK[k] << LG[k];
        end
        base = a - (a % len);
    endfunction

    // Monitor: pops expected clear requests and done events.
    always @(negedge clk) begin
        if (!rst) begin
            if (clr_req_o) begin
                if (clr_q.size() == 0) begin
                    chk("R11 unexpected clear request", 1, 0);
                end else begin
                    clr_item_t it;
                    it = clr_q.pop_front();
                    chk({it.tag, " clear base"}, int'(clr_base_o), it.base);
                    chk({it.tag, " clear len"}, int'(clr_len_o), it.len);
                end
            end
            if (done_o) begin
                if (done_q.size() == 0) begin
                    chk("R13 unexpected done", 1, 0);
                end else begin
                    bit b;
                    b = done_q.pop_front();
                    chk("R10 done bypass", int'(done_bypass_o), int'(b));
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_program(logic [7:0] d);
        program_i   = 1'b1;
        prog_data_i = d;
        step();
        program_i   = 1'b0;
        exp_status[7] = ~d[7];
        chk("R2 status after program", int'(status_o), int'(exp_status));
        chk("R2 busy after program", int'(busy_o), 0);
    endtask

    task automatic do_read(string tag);
        logic was_busy;
        was_busy    = busy_o;
        status_rd_i = 1'b1;
        step();
        status_rd_i = 1'b0;
        if (was_busy) exp_status[6] = ~exp_status[6];
        chk(tag, int'(status_o), int'(exp_status));
    endtask

    // Starts an erase, returns the cycle stamp of the accepting edge.
    task automatic start_erase(bit chip, int addr, bit want_done, string tag, output int stamp);
        clr_item_t it;
        if (chip) begin
            it.base = 0;
            it.len  = CHIP_LEN;
        end else begin
            sector_of(addr, it.base, it.len);
        end
        it.tag = tag;
        clr_q.push_back(it);
        if (want_done) done_q.push_back(bypass_i);
        erase_chip_i   = chip;
        erase_sector_i = ~chip;
        op_addr_i      = ADDR_W'(addr);
        step();
        erase_chip_i   = 1'b0;
        erase_sector_i = 1'b0;
        stamp = cyc;
        exp_status[7] = 1'b0;
        chk("R4 busy after start", int'(busy_o), 1);
        chk("R4 status after start", int'(status_o), int'(exp_status));
    endtask

    task automatic finish_erase(int stamp, int n, string tag);
        while (busy_o) step();
        chk(tag, cyc - stamp, n);
        exp_status[7] = ~exp_status[7];
        chk("R9 status after expiry", int'(status_o), int'(exp_status));
        step();
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int st;
        step(); step();
        rst = 1'b0;
        step();
        // R1
        chk("R1 reset status", int'(status_o), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset clear req", int'(clr_req_o), 0);

        // R2 programming
        do_program(8'h80);
        do_program(8'h3C);
        do_program(8'hFF);
        do_program(8'h01);
        // R3 idle read no effect
        do_read("R3 idle read");

        // R5 chip erase with reads and ignored strobes
        bypass_i = 1'b0;
        start_erase(1'b1, 0, 1'b1, "R5", st);
        do_read("R3 busy read 1");
        do_read("R3 busy read 2");
        do_read("R3 busy read 3");
        // R11 strobes while busy
        erase_sector_i = 1'b1; op_addr_i = 16'h1234; step(); erase_sector_i = 1'b0;
        program_i = 1'b1; prog_data_i = 8'h00; step(); program_i = 1'b0;
        erase_chip_i = 1'b1; step(); erase_chip_i = 1'b0;
        chk("R11 status unchanged", int'(status_o), int'(exp_status));
        finish_erase(st, CHIP_N, "R8 R11 chip busy length");

        // R6 sector erases across region edges, bypass active
        bypass_i = 1'b1;
        start_erase(1'b0, 16'h0ABC, 1'b1, "R6 region0", st);
        finish_erase(st, SEC_N, "R8 sector busy length");
        start_erase(1'b0, 16'h1234, 1'b1, "R6 region1", st);
        do_read("R3 busy read sector");
        finish_erase(st, SEC_N, "R8 sector busy length");
        bypass_i = 1'b0;
        start_erase(1'b0, 16'h5FFF, 1'b1, "R6 region2 top", st);
        finish_erase(st, SEC_N, "R8 sector busy length");
        start_erase(1'b0, 16'h6000, 1'b1, "R6 region3 start", st);
        finish_erase(st, SEC_N, "R8 sector busy length");
        start_erase(1'b0, 16'h0FFF, 1'b1, "R6 region0 top", st);
        finish_erase(st, SEC_N, "R8 sector busy length");
        start_erase(1'b0, 16'h1000, 1'b1, "R6 region1 start", st);
        finish_erase(st, SEC_N, "R8 sector busy length");
        // R7 beyond array
        start_erase(1'b0, 16'h9ABC, 1'b1, "R7 beyond end", st);
        finish_erase(st, SEC_N, "R8 sector busy length");

        // R12 chip beats sector
        begin
            clr_item_t it;
            it.base = 0; it.len = CHIP_LEN; it.tag = "R12 chip over sector";
            clr_q.push_back(it);
            done_q.push_back(1'b0);
            erase_chip_i = 1'b1; erase_sector_i = 1'b1; op_addr_i = 16'h2000;
            step();
            erase_chip_i = 1'b0; erase_sector_i = 1'b0;
            st = cyc;
            exp_status[7] = 1'b0;
            finish_erase(st, CHIP_N, "R12 chip busy length");
        end
        // R12 sector beats program
        begin
            clr_item_t it;
            sector_of(16'h2345, it.base, it.len);
            it.tag = "R12 sector over program";
            clr_q.push_back(it);
            done_q.push_back(1'b0);
            erase_sector_i = 1'b1; program_i = 1'b1; prog_data_i = 8'h00; op_addr_i = 16'h2345;
            step();
            erase_sector_i = 1'b0; program_i = 1'b0;
            st = cyc;
            exp_status[7] = 1'b0;
            chk("R12 program not applied", int'(status_o), int'(exp_status));
            finish_erase(st, SEC_N, "R12 sector busy length");
        end

        // R13 reset during busy
        start_erase(1'b0, 16'h0100, 1'b0, "R13 pre-reset", st);
        do_read("R3 busy read before reset");
        step(); step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        exp_status = 8'h00;
        chk("R13 busy after reset", int'(busy_o), 0);
        chk("R13 status after reset", int'(status_o), 0);
        for (int i = 0; i < SEC_N + 5; i++) step();
        chk("R13 still idle", int'(busy_o), 0);
        chk("R13 status stable", int'(status_o), 0);

        chk("R5 R6 all clear requests seen", clr_q.size(), 0);
        chk("R9 all done events seen", done_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule